// File: doc/BRIEF.md
# Push-Button LIFO Stack Controller

This block runs a last-in-first-out stack kept in a small single-port synchronous RAM. The RAM is built into the design. Three active-low command buttons drive it, and a switch value supplies the data. A holding register, the memory buffer register (MBR), carries words between the switches and the stack. A pointer register always names the next free word. That pointer feeds the RAM address directly and starts at zero.

A state machine with a fixed 3-bit code carries out each command. A store takes two cycles: one with write enable raised, then one that drops it and advances the pointer. A fetch steps the pointer back first. It then spends two cycles waiting for the RAM to settle on the new address, and captures the RAM output on the third. Every command ends in a state that holds until all buttons are released, so one press runs exactly one command. The buttons are plain level controls with no handshake. The MBR, the pointer and the state code are driven out continuously. The block assumes the buttons are already debounced.

Top module: `stack_ctrl`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, `buf_q`, `sp_q` and `st_code` all read zero. The reset is asynchronous.
- R2: In idle (code 000), a low `ld_n` copies `sw_val` into `buf_q` on the next clock edge, and `st_code` becomes 111.
- R3: In idle, a low `push_n` (with `ld_n` high) moves to 001. On the edge after that, the MBR is written at address `sp_q`, `sp_q` is incremented and the state becomes 111.
- R4: In idle, a low `pop_n` (with `ld_n` and `push_n` high) and a nonzero `sp_q` decrements `sp_q` and moves to 100. The state then steps 100, 101, 110, 111, and `buf_q` holds the word at the new pointer once 111 is reached.
- R5: A pop request while `sp_q` is zero does nothing. The state stays 000, and `sp_q` and `buf_q` are unchanged.
- R6: State 111 holds while any of `ld_n`, `push_n`, `pop_n` is low. On the first edge where all three are high, it returns to 000.
- R7: When several buttons are low in idle, load wins over push and push wins over pop.
- R8: A push while `sp_q` is 15 writes word 15 and wraps `sp_q` to 0. There is no full indication. The next push writes word 0, and a pop then returns it.
- R9: Words come back in reverse order of storage. After pushing 1, 2, 3, three pops give 3, 2, 1 in `buf_q`.
- R10: The state codes are: 000 idle, 001 write, 100 and 101 read delay, 110 capture, 111 release wait. The unused codes 010 and 011 return to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_val | input | DW | Switch value to load into the MBR |
| ld_n | input | 1 | Load button, low when pressed |
| push_n | input | 1 | Push button, low when pressed |
| pop_n | input | 1 | Pop button, low when pressed |
| buf_q | output | DW | Current MBR contents |
| sp_q | output | AW | Stack pointer (next free word) |
| st_code | output | 3 | Controller state code |

## Verification
The bench uses the default widths: 4-bit words and a 4-bit pointer over 16 words. With these widths, a full sweep of sixteen pushes fits in a few hundred cycles. That brings the pointer wrap from 15 to 0, and the ignored pop at zero that follows it, into a directed test. The 4-bit data width also lets the 1, 2, 3 pattern and a zero marker be told apart in the MBR after each pop.

// File: rtl/stack_ctrl_pkg.sv
package stack_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'b000,
    ST_WR   = 3'b001,
    ST_DLY1 = 3'b100,
    ST_DLY2 = 3'b101,
    ST_CAP  = 3'b110,
    ST_REL  = 3'b111
  } stk_state_e;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_LOAD,
    CMD_PUSH,
    CMD_POP
  } stk_cmd_e;
endpackage

// File: rtl/stack_ram.sv
module stack_ram #(
  parameter int DW = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] addr_q;

  // address and write inputs are registered; the read shows the registered address
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    addr_q <= addr;
  end

  assign rdata = mem[addr_q];
endmodule

// File: rtl/stack_cmd_dec.sv
module stack_cmd_dec
  import stack_ctrl_pkg::*;
(
  input  logic     ld_n,
  input  logic     push_n,
  input  logic     pop_n,
  output stk_cmd_e cmd,
  output logic     all_up
);
  // fixed priority: load, then push, then pop
  always_comb begin
    if (!ld_n)        cmd = CMD_LOAD;
    else if (!push_n) cmd = CMD_PUSH;
    else if (!pop_n)  cmd = CMD_POP;
    else              cmd = CMD_NONE;
  end

  assign all_up = ld_n & push_n & pop_n;
endmodule

// File: rtl/stack_fsm.sv
module stack_fsm
  import stack_ctrl_pkg::*;
#(
  parameter int DW = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  stk_cmd_e      cmd,
  input  logic          all_up,
  input  logic [DW-1:0] sw_val,
  input  logic [DW-1:0] ram_rd,
  output logic [DW-1:0] ram_wd,
  output logic          ram_we,
  output logic [AW-1:0] sp,
  output logic [DW-1:0] mbr,
  output stk_state_e    state
);
  localparam logic [AW-1:0] SP_ZERO = '0;
  localparam logic [AW-1:0] SP_ONE  = {{(AW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      sp     <= SP_ZERO;
      mbr    <= '0;
      ram_wd <= '0;
      ram_we <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          case (cmd)
            CMD_LOAD: begin
              mbr   <= sw_val;
              state <= ST_REL;
            end
            CMD_PUSH: begin
              ram_wd <= mbr;
              ram_we <= 1'b1;
              state  <= ST_WR;
            end
            CMD_POP: begin
              if (sp != SP_ZERO) begin
                sp    <= sp - SP_ONE;
                state <= ST_DLY1;
              end
            end
            default: state <= ST_IDLE;
          endcase
        end
        ST_WR: begin
          ram_we <= 1'b0;
          sp     <= sp + SP_ONE;
          state  <= ST_REL;
        end
        ST_DLY1: state <= ST_DLY2;
        ST_DLY2: state <= ST_CAP;
        ST_CAP: begin
          mbr   <= ram_rd;
          state <= ST_REL;
        end
        ST_REL: begin
          if (all_up) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stack_ctrl.sv
module stack_ctrl
  import stack_ctrl_pkg::*;
#(
  parameter int DW = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] sw_val,
  input  logic          ld_n,
  input  logic          push_n,
  input  logic          pop_n,
  output logic [DW-1:0] buf_q,
  output logic [AW-1:0] sp_q,
  output logic [2:0]    st_code
);
  stk_cmd_e      cmd;
  logic          all_up;
  logic [DW-1:0] ram_wd;
  logic [DW-1:0] ram_rd;
  logic          ram_we;
  logic [AW-1:0] sp;
  logic [DW-1:0] mbr;
  stk_state_e    state;

  stack_cmd_dec u_dec (
    .ld_n   (ld_n),
    .push_n (push_n),
    .pop_n  (pop_n),
    .cmd    (cmd),
    .all_up (all_up)
  );

  stack_fsm #(.DW(DW), .AW(AW)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd),
    .all_up (all_up),
    .sw_val (sw_val),
    .ram_rd (ram_rd),
    .ram_wd (ram_wd),
    .ram_we (ram_we),
    .sp     (sp),
    .mbr    (mbr),
    .state  (state)
  );

  stack_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk   (clk),
    .addr  (sp),
    .we    (ram_we),
    .wdata (ram_wd),
    .rdata (ram_rd)
  );

  assign buf_q   = mbr;
  assign sp_q    = sp;
  assign st_code = state;
endmodule

// File: rtl/stack_ctrl_chk.sv
module stack_ctrl_chk #(
  parameter int DW = 4,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] sw_val,
  input logic          ld_n,
  input logic          push_n,
  input logic          pop_n,
  input logic [DW-1:0] buf_q,
  input logic [AW-1:0] sp_q,
  input logic [2:0]    st_code
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 3'b000 && !ld_n) |=> (st_code == 3'b111 && buf_q == $past(sw_val)));

  // R3
  write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 3'b001) |=> (st_code == 3'b111 && sp_q == $past(sp_q) + ONE));

  // R4
  pop_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 3'b000 && ld_n && push_n && !pop_n && sp_q != '0)
      |=> (st_code == 3'b100 && sp_q == $past(sp_q) - ONE));

  // R5
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 3'b000 && ld_n && push_n && !pop_n && sp_q == '0)
      |=> (st_code == 3'b000 && sp_q == '0 && $stable(buf_q)));

  // R6
  release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 3'b111 && !(ld_n && push_n && pop_n)) |=> (st_code == 3'b111));

  // R7
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 3'b000 && !ld_n) |=> $stable(sp_q));

  // R10
  delay_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 3'b100) |=> (st_code == 3'b101));

  // R10
  capture_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 3'b101) |=> (st_code == 3'b110));

  // R10
  capture_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 3'b110) |=> (st_code == 3'b111 && $stable(sp_q)));
endmodule

bind stack_ctrl stack_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sw_val  (sw_val),
  .ld_n    (ld_n),
  .push_n  (push_n),
  .pop_n   (pop_n),
  .buf_q   (buf_q),
  .sp_q    (sp_q),
  .st_code (st_code)
);

// File: tb/stack_ctrl_tb.sv
module stack_ctrl_tb;
  localparam int DW = 4;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] sw_val = '0;
  logic          ld_n = 1'b1;
  logic          push_n = 1'b1;
  logic          pop_n = 1'b1;
  logic [DW-1:0] buf_q;
  logic [AW-1:0] sp_q;
  logic [2:0]    st_code;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  logic [AW-1:0] exp_sp = '0;

  always #5 clk = ~clk;

  stack_ctrl #(.DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_val(sw_val), .ld_n(ld_n),
    .push_n(push_n), .pop_n(pop_n), .buf_q(buf_q), .sp_q(sp_q), .st_code(st_code)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_err = n_err + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog: act=%0d exp=<50000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_err = n_err + 1;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic press(input logic l, input logic p, input logic q);
    @(negedge clk);
    ld_n = ~l; push_n = ~p; pop_n = ~q;
  endtask

  task automatic release_all;
    @(negedge clk);
    ld_n = 1'b1; push_n = 1'b1; pop_n = 1'b1;
    @(negedge clk);
    chk("R6 idle after release", st_code, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 buf in reset", buf_q, 0);
    chk("R1 sp in reset", sp_q, 0);
    chk("R1 state in reset", st_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state after reset", st_code, 0);
    exp_sp = '0;
  endtask

  task automatic do_load(input logic [DW-1:0] v);
    sw_val = v;
    press(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R2 load state", st_code, 7);
    chk("R2 load value", buf_q, v);
    release_all();
  endtask

  task automatic do_push;
    press(1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R10 write code", st_code, 1);
    @(negedge clk);
    chk("R3 push state", st_code, 7);
    exp_sp = exp_sp + 1'b1;
    chk("R3 sp after push", sp_q, exp_sp);
    release_all();
  endtask

  task automatic do_pop(input logic [DW-1:0] v);
    press(1'b0, 1'b0, 1'b1);
    @(negedge clk);
    exp_sp = exp_sp - 1'b1;
    chk("R4 pop first code", st_code, 4);
    chk("R4 sp after pop", sp_q, exp_sp);
    @(negedge clk);
    chk("R10 delay code", st_code, 5);
    @(negedge clk);
    chk("R10 capture code", st_code, 6);
    @(negedge clk);
    chk("R4 pop end code", st_code, 7);
    chk("R9 popped value", buf_q, v);
    release_all();
  endtask

  task automatic t_lifo;
    do_load(4'd1); do_push();
    do_load(4'd2); do_push();
    do_load(4'd3); do_push();
    do_load(4'd0);
    do_pop(4'd3);
    do_pop(4'd2);
    do_pop(4'd1);
  endtask

  task automatic t_pop_empty;
    logic [DW-1:0] keep;
    keep = buf_q;
    press(1'b0, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    chk("R5 state stays idle", st_code, 0);
    chk("R5 sp stays zero", sp_q, 0);
    chk("R5 buf unchanged", buf_q, keep);
    release_all();
  endtask

  task automatic t_release_hold;
    sw_val = 4'd6;
    press(1'b1, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R6 held in release", st_code, 7);
    ld_n = 1'b1; pop_n = 1'b0;
    @(negedge clk);
    chk("R6 held other button", st_code, 7);
    chk("R6 no pop while held", sp_q, exp_sp);
    release_all();
  endtask

  task automatic t_priority;
    sw_val = 4'd11;
    press(1'b1, 1'b1, 1'b1);
    @(negedge clk);
    chk("R7 load wins state", st_code, 7);
    chk("R7 load wins value", buf_q, 11);
    chk("R7 load wins sp", sp_q, exp_sp);
    release_all();
    press(1'b0, 1'b1, 1'b1);
    @(negedge clk);
    chk("R7 push beats pop", st_code, 1);
    @(negedge clk);
    exp_sp = exp_sp + 1'b1;
    chk("R7 push sp", sp_q, exp_sp);
    release_all();
    do_pop(4'd11);
  endtask

  task automatic t_wrap;
    for (int i = 0; i < 16; i++) begin
      do_load(4'(i + 1));
      do_push();
    end
    chk("R8 sp wrapped", sp_q, 0);
    t_pop_empty();
    do_load(4'd9); do_push();
    do_load(4'd0);
    do_pop(4'd9);
    chk("R8 sp back to zero", sp_q, 0);
  endtask

  initial begin
    t_reset();
    t_lifo();
    t_pop_empty();
    t_release_hold();
    t_priority();
    t_reset();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule